// File: doc/BRIEF.md
# NAND Flash Bus Glue Decoder

This block sits between a byte-wide microcontroller external memory bus and two parts: a raw NAND flash device and an SRAM. The 16-bit bus address is assembled from a latched low byte and a high port byte. Fixed windows in that address space map to the SRAM and to the three NAND register functions: command, address and page data. The block drives the flash control lines and the SRAM chip enable. The data bus itself runs directly between the bus and the parts and does not pass through this block.

Software reaches the NAND with ordinary byte stores and loads. It issues a command by writing the command location and sends address bytes by writing the address location. It moves page bytes through a data window whose size is the next power of two above the page size including the spare area. A whole page can therefore be copied with a pointer that simply increments. Reading the command location returns the flash ready/busy pin without starting a flash cycle.

The decode is registered: the chip enables, CLE and ALE are taken from the address seen at the previous clock edge. The bus address must settle one clock before the strobe falls, and CLE and ALE stay steady for as long as the address is held, including past the rising edge of the write strobe.

Top module: `nand_glue_top`

## Requirements
- R1: Write cycles on address 0x7FFE drive `nand_cle` high and `nand_ale` low. This is a NAND command cycle.
- R2: Write cycles on address 0x7FFF drive `nand_ale` high and `nand_cle` low. This is a NAND address cycle.
- R3: Any address from 0x8000 to 0x83FF selects the NAND data window when `page_big` = 0. The range is 0x8000 to 0x8FFF when `page_big` = 1. In this window `nand_ce_n` is low and both CLE and ALE are low.
- R4: Addresses 0x0000 to 0x7FFD drive `sram_ce_n` low and `nand_ce_n` high. Addresses 0x7FFE, 0x7FFF and the data window drive `nand_ce_n` low and `sram_ce_n` high. All other addresses leave both enables high. The two enables are never low together.
- R5: `nand_we_n` equals `bus_wr_n` while the NAND is selected (command, address or data window) and is high otherwise. `nand_re_n` equals `bus_rd_n` only in the data window and is high otherwise.
- R6: While `bus_rd_n` is low with 0x7FFE decoded, `rdback_oe` is 1 and `rdback_data` is `nand_rb` in bit 0 with all other bits 0. At all other times `rdback_oe` is 0 and `rdback_data` is 0. No RE_n pulse is generated by this read.
- R7: While `bus_rd_n` is low, CLE and ALE are both low. A read at 0x7FFF produces no strobe on the flash.
- R8: `nand_wp_n` is held high at all times.
- R9: While `rst` is high, every output is at its inactive level: the enables, WE_n, RE_n and WP_n are high, and CLE, ALE, `rdback_oe` and `rdback_data` are low.
- R10: The chip enables, CLE, ALE and the window choice follow the address and `page_big` sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_lo | input | 8 | Latched low address byte |
| bus_addr_hi | input | 8 | High address byte |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| page_big | input | 1 | 0: 1024-byte data window, 1: 4096-byte data window |
| nand_rb | input | 1 | Flash ready/busy pin, 1 = ready |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Flash command latch enable |
| nand_ale | output | 1 | Flash address latch enable |
| nand_we_n | output | 1 | Flash write enable, active low |
| nand_re_n | output | 1 | Flash read enable, active low |
| nand_wp_n | output | 1 | Flash write protect, active low |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| rdback_oe | output | 1 | Drive status byte onto the data bus |
| rdback_data | output | 8 | Status byte |

## Verification
The bench runs a fixed sequence of writes and reads. It covers the command location, repeated address-location writes, both data-window edges, the bytes just past each window in both page modes, the SRAM top and bottom, unmapped space, and status reads with the ready pin both low and high. This separates a window that is off by one or uses the wrong size from a correct one. It also separates CLE and ALE that are swapped or gated into reads, and a read-enable that leaks into the command or address locations. A long stretch of random accesses with random page mode and random ready pin then exercises strobe timing against the registered decode. A reset pulse in the middle of traffic shows the outputs falling to their inactive levels.

// File: rtl/nand_glue_pkg.sv
package nand_glue_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SRAM,
        RG_CMD,
        RG_ADR,
        RG_DATA
    } region_e;

    typedef struct packed {
        logic sram_sel;
        logic nand_sel;
        logic cmd;
        logic adr;
        logic dat;
    } sel_s;

    function automatic sel_s region_to_sel(input region_e r);
        sel_s s;
        s.sram_sel = (r == RG_SRAM);
        s.cmd      = (r == RG_CMD);
        s.adr      = (r == RG_ADR);
        s.dat      = (r == RG_DATA);
        s.nand_sel = s.cmd | s.adr | s.dat;
        return s;
    endfunction

endpackage

// File: rtl/nand_glue_decode.sv
module nand_glue_decode
    import nand_glue_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 16'h7FFE,
    parameter logic [ADDR_W-1:0] ADR_ADDR  = 16'h7FFF,
    parameter logic [ADDR_W-1:0] SRAM_LAST = 16'h7FFD,
    parameter logic [ADDR_W-1:0] DATA_BASE = 16'h8000,
    parameter int WIN_SMALL_W = 10,
    parameter int WIN_BIG_W   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              big,
    output sel_s              sel_q
);
    localparam logic [ADDR_W-1:0] BASE_SMALL = DATA_BASE >> WIN_SMALL_W;
    localparam logic [ADDR_W-1:0] BASE_BIG   = DATA_BASE >> WIN_BIG_W;

    region_e region;
    logic    in_win;

    always_comb begin
        if (big) in_win = ((addr >> WIN_BIG_W) == BASE_BIG);
        else     in_win = ((addr >> WIN_SMALL_W) == BASE_SMALL);
    end

    always_comb begin
        if (addr == CMD_ADDR)       region = RG_CMD;
        else if (addr == ADR_ADDR)  region = RG_ADR;
        else if (addr <= SRAM_LAST) region = RG_SRAM;
        else if (in_win)            region = RG_DATA;
        else                        region = RG_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= region_to_sel(region);
    end

    // R10: the selection one edge later reflects the address of this edge
    a_r10_cmd_lag: assert property (@(posedge clk) disable iff (rst)
        (addr == CMD_ADDR) |=> (sel_q.cmd && sel_q.nand_sel && !sel_q.sram_sel));
    a_r10_sram_lag: assert property (@(posedge clk) disable iff (rst)
        (addr < SRAM_LAST) |=> (sel_q.sram_sel && !sel_q.nand_sel));
    // R3: the decoded data window never overlaps the register locations
    a_r3_data_excl: assert property (@(posedge clk) disable iff (rst)
        sel_q.dat |-> !(sel_q.cmd || sel_q.adr || sel_q.sram_sel));

endmodule

// File: rtl/nand_glue_strobe.sv
module nand_glue_strobe
    import nand_glue_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  sel_s              sel_q,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              rb,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic              nand_wp_n,
    output logic              sram_ce_n,
    output logic              rdback_oe,
    output logic [DATA_W-1:0] rdback_data
);
    logic live;
    assign live = !rst;

    always_comb begin
        nand_ce_n   = !(live && sel_q.nand_sel);
        sram_ce_n   = !(live && sel_q.sram_sel);
        nand_cle    = live && sel_q.cmd && rd_n;
        nand_ale    = live && sel_q.adr && rd_n;
        nand_we_n   = !(live && sel_q.nand_sel && !wr_n);
        nand_re_n   = !(live && sel_q.dat && !rd_n);
        nand_wp_n   = 1'b1;
        rdback_oe   = live && sel_q.cmd && !rd_n;
        rdback_data = rdback_oe ? {{(DATA_W-1){1'b0}}, rb} : '0;
    end

    // R4: never both parts enabled
    a_r4_one_ce: assert property (@(posedge clk) disable iff (rst)
        nand_ce_n || sram_ce_n);
    // R1: command latch excludes address latch and needs the flash enabled
    a_r1_cle_excl: assert property (@(posedge clk) disable iff (rst)
        nand_cle |-> (!nand_ale && !nand_ce_n && sram_ce_n));
    // R5: a read-enable pulse is never a command or address cycle
    a_r5_re_data: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> (!nand_ce_n && !nand_cle && !nand_ale));
    // R6: status readback never strobes the flash read
    a_r6_no_re_status: assert property (@(posedge clk) disable iff (rst)
        rdback_oe |-> (nand_re_n && !nand_cle));
    // R9: inactive levels under reset
    a_r9_reset_idle: assert property (@(posedge clk)
        rst |-> (nand_ce_n && sram_ce_n && !nand_cle && !nand_ale
                 && nand_we_n && nand_re_n && !rdback_oe));

endmodule

// File: rtl/nand_glue_top.sv
module nand_glue_top
    import nand_glue_pkg::*;
#(
    parameter int LO_W   = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LO_W-1:0]        bus_addr_lo,
    input  logic [ADDR_W-LO_W-1:0] bus_addr_hi,
    input  logic                   bus_wr_n,
    input  logic                   bus_rd_n,
    input  logic                   page_big,
    input  logic                   nand_rb,
    output logic                   nand_ce_n,
    output logic                   nand_cle,
    output logic                   nand_ale,
    output logic                   nand_we_n,
    output logic                   nand_re_n,
    output logic                   nand_wp_n,
    output logic                   sram_ce_n,
    output logic                   rdback_oe,
    output logic [DATA_W-1:0]      rdback_data
);
    logic [ADDR_W-1:0] addr_full;
    sel_s              sel_q;

    assign addr_full = {bus_addr_hi, bus_addr_lo};

    nand_glue_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk   (clk),
        .rst   (rst),
        .addr  (addr_full),
        .big   (page_big),
        .sel_q (sel_q)
    );

    nand_glue_strobe #(.DATA_W(DATA_W)) u_strobe (
        .clk         (clk),
        .rst         (rst),
        .sel_q       (sel_q),
        .wr_n        (bus_wr_n),
        .rd_n        (bus_rd_n),
        .rb          (nand_rb),
        .nand_ce_n   (nand_ce_n),
        .nand_cle    (nand_cle),
        .nand_ale    (nand_ale),
        .nand_we_n   (nand_we_n),
        .nand_re_n   (nand_re_n),
        .nand_wp_n   (nand_wp_n),
        .sram_ce_n   (sram_ce_n),
        .rdback_oe   (rdback_oe),
        .rdback_data (rdback_data)
    );

endmodule

// File: tb/nand_glue_top_bench.sv
`timescale 1ns/1ps
module nand_glue_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] lo = 8'h00, hi = 8'hFF;
    logic       wr_n = 1'b1, rd_n = 1'b1, big = 1'b0, rb = 1'b1;
    logic       ce_n, cle, ale, we_n, re_n, wp_n, sce_n, oe;
    logic [7:0] rdat;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;
    int exp_rg = 0; // 0 none, 1 sram, 2 cmd, 3 adr, 4 data

    always #4 clk = ~clk;

    nand_glue_top u_nand_glue_top (
        .clk(clk), .rst(rst), .bus_addr_lo(lo), .bus_addr_hi(hi),
        .bus_wr_n(wr_n), .bus_rd_n(rd_n), .page_big(big), .nand_rb(rb),
        .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n),
        .nand_re_n(re_n), .nand_wp_n(wp_n), .sram_ce_n(sce_n),
        .rdback_oe(oe), .rdback_data(rdat)
    );

    function automatic int map_addr(input int a, input bit b);
        if (a == 32'h7FFE) return 2;
        if (a == 32'h7FFF) return 3;
        if (a <= 32'h7FFD) return 1;
        if (!b && a >= 32'h8000 && a <= 32'h83FF) return 4; // R3 small window
        if (b && a >= 32'h8000 && a <= 32'h8FFF) return 4;  // R3 big window
        return 0;
    endfunction

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, nm, act, exp, $time);
        end
    endtask

    // R10: reference decode registered at each rising edge
    always @(posedge clk) begin
        exp_rg <= rst ? 0 : map_addr({hi, lo}, big);
        cycles <= cycles + 1;
    end

    always @(posedge clk) begin
        #2;
        if (!done) begin
            bit nsel;
            string t;
            nsel = (exp_rg >= 2);
            t = rst ? "R9" : "";
            chk(rst ? t : "R4/R10", "nand_ce_n", ce_n, rst ? 1 : !nsel);
            chk(rst ? t : "R4", "sram_ce_n", sce_n, rst ? 1 : (exp_rg != 1));
            chk(rst ? t : "R1/R7", "cle", cle, rst ? 0 : (exp_rg == 2 && rd_n));
            chk(rst ? t : "R2/R7", "ale", ale, rst ? 0 : (exp_rg == 3 && rd_n));
            chk(rst ? t : "R5", "we_n", we_n, rst ? 1 : (wr_n || !nsel));
            chk(rst ? t : "R5/R3", "re_n", re_n, rst ? 1 : (rd_n || exp_rg != 4));
            chk(rst ? t : "R6", "rdback_oe", oe, rst ? 0 : (!rd_n && exp_rg == 2));
            chk(rst ? t : "R6", "rdback_data", rdat,
                (!rst && !rd_n && exp_rg == 2) ? {7'b0, rb} : 0);
            chk("R8", "wp_n", wp_n, 1);
        end
    end

    task automatic access(input int a, input bit is_wr);
        @(negedge clk);
        {hi, lo} = a[15:0];
        @(negedge clk);
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_n = 1'b1;
        rd_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 command, R2 address cycles
        access(32'h7FFE, 1);
        for (int i = 0; i < 3; i++) access(32'h7FFF, 1);
        // R3 window edges, small mode
        access(32'h8000, 1);
        access(32'h83FF, 1);
        access(32'h8001, 0);
        access(32'h8400, 0);
        access(32'h7FFF, 1'b0); // R7 read of address location
        // R3 big mode
        big = 1'b1;
        access(32'h8400, 0);
        access(32'h8FFF, 1);
        access(32'h9000, 0);
        // R6 status with busy and ready
        rb = 1'b0; access(32'h7FFE, 0);
        rb = 1'b1; access(32'h7FFE, 0);
        // R4 SRAM edges and unmapped space
        access(32'h7FFD, 1);
        access(32'h0000, 0);
        access(32'hFFFF, 1);
        access(32'h7FFE, 1);
        // random traffic
        for (int i = 0; i < 400; i++) begin
            int a;
            case ($urandom_range(0, 4))
                0: a = 32'h7FFE;
                1: a = 32'h7FFF;
                2: a = 32'h8000 + $urandom_range(0, 32'h1FFF);
                3: a = $urandom_range(0, 32'h7FFD);
                default: a = $urandom_range(0, 32'hFFFF);
            endcase
            big = 1'($urandom_range(0, 1));
            rb  = 1'($urandom_range(0, 1));
            access(a, 1'($urandom_range(0, 1)));
            if (i == 200) begin
                // R9 reset pulse during traffic
                {hi, lo} = 16'h7FFE;
                wr_n = 1'b0;
                rst = 1'b1;
                repeat (3) @(negedge clk);
                wr_n = 1'b1;
                rst = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule